// File: doc/BRIEF.md
# Token-Ordered Multi-Link Event Readout Controller

This block collects 32-bit words from a group of input links, each of which already presents parallel words with a valid strobe. Every link has its own small buffer. When a token arrives, the controller visits the links in ascending index order and moves one event from the current link onto a single shared output. An event is a run of words that ends with a trailer word. Once the last link has been served, the controller hands the token on to the next controller in the chain.

Each link carries a 2-bit per-trigger mode that is sampled when the token arrives. The mode can read the link normally, hold its data back for a later trigger, flush its whole buffer, or drop the oldest event and send the next one. These modes let one link be moved forward or back relative to the others to restore event alignment. A static off bit removes a link from readout. The controller also reports links that never deliver a trailer, writes that arrive at a full buffer, and buffers that hold too many complete events. A halt input freezes the output.

Top module: `link_readout_ctrl`

## Requirements
- R1: While it holds the token, the block serves links in ascending index order. In mode 00 it outputs the current link's words in arrival order, up to and including the first trailer, then moves on. A trailer is any word whose bits [31:28] equal 4'hE.
- R2: Nothing is output until a one-cycle `token_in` pulse is accepted. After the last link is done, `token_out` pulses high for exactly one cycle.
- R3: Mode 01 reads nothing from the link for this token, so its buffered event remains available to a later token.
- R4: Mode 10 outputs nothing from the link and removes every word that was buffered for it.
- R5: Mode 11 discards the link's oldest event, including its trailer, and outputs the next event.
- R6: A link whose `link_off` bit is set is skipped whatever its mode, and its buffered data is left untouched.
- R7: In modes 00 and 11, if the link's buffer stays empty for `tmo_cycles` unhalted cycles, the block outputs the word 32'hEF00_0000 plus the link index, sets that link's bit in `tmo_flag` (sticky), and moves on.
- R8: A word that arrives while its link buffer already holds DEPTH (256) words is dropped, and the link's `ovf_flag` bit is set and stays set.
- R9: `ht_limit[i]` is high while link i buffers at least HT_LIMIT (4) trailers. `busy` follows the OR of `ht_limit` one cycle later.
- R10: `trailer_pulse` is high for exactly the cycles in which the output word is a trailer, including a timeout word, so that the pending-trigger count can be decremented.
- R11: While `halt` is high, no word is read from any buffer, `out_valid` is low in the following cycle, and the timeout count does not advance.
- R12: After reset, `out_valid`, `token_out`, `trailer_pulse`, `busy` and all flag vectors are low, and all buffers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lnk_data | input | NLINK*WIDTH | Word from each link; link i uses bits [i*32 +: 32] |
| lnk_valid | input | NLINK | Per-link word strobe |
| link_off | input | NLINK | Static per-link off bit |
| link_mode | input | 2*NLINK | Per-link mode, link i in bits [2i+1:2i], sampled on token |
| tmo_cycles | input | 16 | Empty-buffer cycles before a timeout |
| token_in | input | 1 | Token from the previous controller |
| halt | input | 1 | Output stall request |
| out_data | output | WIDTH | Output word |
| out_valid | output | 1 | Output word strobe |
| token_out | output | 1 | Token to the next controller |
| trailer_pulse | output | 1 | Trailer sent, used to decrement the trigger count |
| busy | output | 1 | Some link is at its event limit |
| ht_limit | output | NLINK | Per-link event-count limit reached |
| ovf_flag | output | NLINK | Per-link sticky overflow |
| tmo_flag | output | NLINK | Per-link sticky timeout |

## Verification
A bad link index or a bad mode decode shows up within the same token pass as words that are out of order, missing or extra in the output stream. The bench compares that stream word for word with the expected one. A buffer pointer or trailer-count error appears one token later, when data that should have been held back or flushed comes out wrong, or when `ht_limit` and `busy` disagree with the number of events pushed. A stuck sequencer shows as a missing `token_out` within a bounded number of cycles.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic [1:0] {
    MD_NORMAL = 2'b00,
    MD_HOLD   = 2'b01,
    MD_FLUSH  = 2'b10,
    MD_SECOND = 2'b11
  } lrc_mode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SEL, S_READ, S_DISC, S_FLUSH, S_PASS
  } lrc_state_t;

  localparam logic [3:0] TRL_TAG = 4'hE;
  localparam logic [3:0] TMO_TAG = 4'hF;

  function automatic logic is_trailer(input logic [3:0] tag);
    return tag == TRL_TAG;
  endfunction
endpackage

// File: rtl/lrc_link_fifo.sv
module lrc_link_fifo #(
  parameter int WIDTH    = 32,
  parameter int DEPTH    = 256,
  parameter int HT_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             ovf,
  output logic             lim
);
  import lrc_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count, tcnt, tcnt_nxt;
  logic             full, wr_ok, rd_ok, wr_trl, rd_trl;

  assign full    = count == CW'(DEPTH);
  assign empty   = count == '0;
  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_en && !empty;
  assign rd_data = mem[rptr];
  assign wr_trl  = wr_ok && is_trailer(wr_data[WIDTH-1 -: 4]);
  assign rd_trl  = rd_ok && is_trailer(rd_data[WIDTH-1 -: 4]);

  always_comb begin
    tcnt_nxt = tcnt;
    if (wr_trl && !rd_trl) tcnt_nxt = tcnt + 1'b1;
    else if (rd_trl && !wr_trl) tcnt_nxt = tcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      tcnt  <= '0;
      ovf   <= 1'b0;
      lim   <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      if (wr_ok && !rd_ok) count <= count + 1'b1;
      else if (rd_ok && !wr_ok) count <= count - 1'b1;
      if (wr_en && full) ovf <= 1'b1;
      tcnt <= tcnt_nxt;
      lim  <= tcnt_nxt >= CW'(HT_LIMIT);
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> ovf); // R8
  AST_RD_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty); // R1
endmodule

// File: rtl/lrc_token_seq.sv
module lrc_token_seq #(
  parameter int NLINK = 12,
  parameter int WIDTH = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   token_in,
  input  logic                   halt,
  input  logic [15:0]            tmo_cycles,
  input  logic [NLINK-1:0]       link_off,
  input  logic [2*NLINK-1:0]     link_mode,
  input  logic [NLINK-1:0]       empty,
  input  logic [NLINK*WIDTH-1:0] head_bus,
  output logic [NLINK-1:0]       rd_en,
  output logic [WIDTH-1:0]       out_data,
  output logic                   out_valid,
  output logic                   token_out,
  output logic                   trailer_pulse,
  output logic [NLINK-1:0]       tmo_flag
);
  import lrc_pkg::*;
  localparam int LW = (NLINK > 1) ? $clog2(NLINK) : 1;

  lrc_state_t         state, adv_state;
  logic [LW-1:0]      cur, adv_cur;
  logic [NLINK-1:0]   off_q;
  logic [2*NLINK-1:0] mode_q;
  logic [15:0]        tmo_cnt;
  logic [WIDTH-1:0]   head_w, tmo_word;
  logic               emp, head_trl, rd_go, tmo_hit, last, waiting;
  lrc_mode_t          md;

  always_comb begin
    head_w   = head_bus[cur*WIDTH +: WIDTH];
    emp      = empty[cur];
    head_trl = is_trailer(head_w[WIDTH-1 -: 4]);
    md       = lrc_mode_t'(mode_q[2*cur +: 2]);
    last     = cur == LW'(NLINK-1);
    waiting  = (state == S_READ) || (state == S_DISC);
    rd_go    = !halt && !emp &&
               (waiting || (state == S_FLUSH));
    tmo_hit  = !halt && emp && waiting &&
               ({1'b0, tmo_cnt} + 17'd1 >= {1'b0, tmo_cycles});
    tmo_word = {TRL_TAG, TMO_TAG, {(WIDTH-8-LW){1'b0}}, cur};
    adv_state = last ? S_PASS : S_SEL;
    adv_cur   = last ? cur : cur + 1'b1;
    for (int i = 0; i < NLINK; i++) rd_en[i] = rd_go && (cur == LW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      cur           <= '0;
      off_q         <= '0;
      mode_q        <= '0;
      tmo_cnt       <= '0;
      out_data      <= '0;
      out_valid     <= 1'b0;
      token_out     <= 1'b0;
      trailer_pulse <= 1'b0;
      tmo_flag      <= '0;
    end else begin
      out_valid     <= 1'b0;
      token_out     <= 1'b0;
      trailer_pulse <= 1'b0;
      case (state)
        S_IDLE: if (token_in) begin
          off_q  <= link_off;
          mode_q <= link_mode;
          cur    <= '0;
          state  <= S_SEL;
        end
        S_SEL: begin
          tmo_cnt <= '0;
          if (off_q[cur] || md == MD_HOLD) begin
            state <= adv_state;
            cur   <= adv_cur;
          end else if (md == MD_FLUSH) state <= S_FLUSH;
          else if (md == MD_SECOND) state <= S_DISC;
          else state <= S_READ;
        end
        S_READ, S_DISC: begin
          if (rd_go) begin
            tmo_cnt <= '0;
            if (state == S_READ) begin
              out_data  <= head_w;
              out_valid <= 1'b1;
              if (head_trl) begin
                trailer_pulse <= 1'b1;
                state <= adv_state;
                cur   <= adv_cur;
              end
            end else if (head_trl) begin
              state <= S_READ;
            end
          end else if (tmo_hit) begin
            out_data      <= tmo_word;
            out_valid     <= 1'b1;
            trailer_pulse <= 1'b1;
            tmo_flag[cur] <= 1'b1;
            state <= adv_state;
            cur   <= adv_cur;
          end else if (!halt && emp) begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        S_FLUSH: if (!halt && emp) begin
          state <= adv_state;
          cur   <= adv_cur;
        end
        S_PASS: begin
          token_out <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_HALT_STALL: assert property (@(posedge clk) disable iff (rst)
    halt |=> !out_valid); // R11
  AST_TOKEN_ONE: assert property (@(posedge clk) disable iff (rst)
    token_out |=> !token_out); // R2
  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_en)); // R1
  AST_TRL_VALID: assert property (@(posedge clk) disable iff (rst)
    trailer_pulse |-> (out_valid && out_data[WIDTH-1 -: 4] == TRL_TAG)); // R10
endmodule

// File: rtl/link_readout_ctrl.sv
module link_readout_ctrl #(
  parameter int NLINK    = 12,
  parameter int WIDTH    = 32,
  parameter int DEPTH    = 256,
  parameter int HT_LIMIT = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NLINK*WIDTH-1:0] lnk_data,
  input  logic [NLINK-1:0]       lnk_valid,
  input  logic [NLINK-1:0]       link_off,
  input  logic [2*NLINK-1:0]     link_mode,
  input  logic [15:0]            tmo_cycles,
  input  logic                   token_in,
  input  logic                   halt,
  output logic [WIDTH-1:0]       out_data,
  output logic                   out_valid,
  output logic                   token_out,
  output logic                   trailer_pulse,
  output logic                   busy,
  output logic [NLINK-1:0]       ht_limit,
  output logic [NLINK-1:0]       ovf_flag,
  output logic [NLINK-1:0]       tmo_flag
);
  logic [NLINK-1:0]       empty, rd_en;
  logic [NLINK*WIDTH-1:0] head_bus;

  for (genvar g = 0; g < NLINK; g++) begin : g_link
    lrc_link_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .HT_LIMIT(HT_LIMIT)) i_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (lnk_valid[g]),
      .wr_data (lnk_data[g*WIDTH +: WIDTH]),
      .rd_en   (rd_en[g]),
      .rd_data (head_bus[g*WIDTH +: WIDTH]),
      .empty   (empty[g]),
      .ovf     (ovf_flag[g]),
      .lim     (ht_limit[g])
    );
  end

  lrc_token_seq #(.NLINK(NLINK), .WIDTH(WIDTH)) i_seq (
    .clk           (clk),
    .rst           (rst),
    .token_in      (token_in),
    .halt          (halt),
    .tmo_cycles    (tmo_cycles),
    .link_off      (link_off),
    .link_mode     (link_mode),
    .empty         (empty),
    .head_bus      (head_bus),
    .rd_en         (rd_en),
    .out_data      (out_data),
    .out_valid     (out_valid),
    .token_out     (token_out),
    .trailer_pulse (trailer_pulse),
    .tmo_flag      (tmo_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= |ht_limit;
  end
endmodule

// File: tb/test_link_readout_ctrl.sv
module test_link_readout_ctrl;
  localparam int N = 12;
  localparam int W = 32;

  logic clk = 0;
  logic rst = 1;
  logic [N*W-1:0] lnk_data = '0;
  logic [N-1:0]   lnk_valid = '0;
  logic [N-1:0]   link_off = '1;
  logic [2*N-1:0] link_mode = '0;
  logic [15:0]    tmo_cycles = 16'd20;
  logic token_in = 0, halt = 0;
  logic [W-1:0] out_data;
  logic out_valid, token_out, trailer_pulse, busy;
  logic [N-1:0] ht_limit, ovf_flag, tmo_flag;

  link_readout_ctrl i_link_readout_ctrl (
    .clk(clk), .rst(rst), .lnk_data(lnk_data), .lnk_valid(lnk_valid),
    .link_off(link_off), .link_mode(link_mode), .tmo_cycles(tmo_cycles),
    .token_in(token_in), .halt(halt), .out_data(out_data), .out_valid(out_valid),
    .token_out(token_out), .trailer_pulse(trailer_pulse), .busy(busy),
    .ht_limit(ht_limit), .ovf_flag(ovf_flag), .tmo_flag(tmo_flag));

  always #5 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  int tok_cnt = 0, trl_cnt = 0, first_out_cyc = -1;
  logic [W-1:0] got[$];
  logic [W-1:0] exp[$];

  task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (out_valid) begin
        got.push_back(out_data);
        if (first_out_cyc < 0) first_out_cyc = cyc;
      end
      if (token_out) tok_cnt++;
      if (trailer_pulse) trl_cnt++;
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic push(input int l, input logic [W-1:0] w);
    @(negedge clk);
    lnk_data[l*W +: W] = w;
    lnk_valid[l] = 1'b1;
    @(negedge clk);
    lnk_valid = '0;
  endtask

  task automatic cfg(input int l, input logic on, input logic [1:0] m);
    link_off[l] = !on;
    link_mode[2*l +: 2] = m;
  endtask

  task automatic all_off();
    link_off = '1;
    link_mode = '0;
  endtask

  task automatic run_token();
    int t0;
    got.delete();
    tok_cnt = 0;
    trl_cnt = 0;
    first_out_cyc = -1;
    @(negedge clk);
    token_in = 1;
    t0 = cyc;
    @(negedge clk);
    token_in = 0;
    while (tok_cnt == 0 && cyc - t0 < 5000) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_stream(input string req);
    check(got.size() == exp.size(), req, W'(got.size()), W'(exp.size()));
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      check(got[i] === exp[i], req, got[i], exp[i]);
  endtask

  task automatic t_reset();
    check(out_valid == 0 && token_out == 0 && trailer_pulse == 0, "R12 outputs",
          W'({out_valid, token_out, trailer_pulse}), 0);
    check(busy == 0 && ht_limit == 0 && ovf_flag == 0 && tmo_flag == 0, "R12 flags",
          W'({ht_limit, ovf_flag, tmo_flag}), 0);
    repeat (5) @(negedge clk);
    check(got.size() == 0, "R2 no output without token", W'(got.size()), 0);
  endtask

  task automatic t_normal();
    all_off();
    push(5, 32'h5000_0001); push(5, 32'hE000_0005);
    push(0, 32'h0000_00AA); push(0, 32'h0000_00BB); push(0, 32'hE000_0000);
    push(3, 32'hE000_0003);
    cfg(0, 1, 2'b00); cfg(3, 1, 2'b00); cfg(5, 1, 2'b00);
    exp = '{32'h0000_00AA, 32'h0000_00BB, 32'hE000_0000, 32'hE000_0003,
            32'h5000_0001, 32'hE000_0005};
    run_token();
    cmp_stream("R1 link order");
    check(tok_cnt == 1, "R2 token_out pulse", W'(tok_cnt), 1);
    check(trl_cnt == 3, "R10 trailer pulses", W'(trl_cnt), 3);
  endtask

  task automatic t_hold();
    all_off();
    push(1, 32'h1000_0011); push(1, 32'hE000_0011);
    push(2, 32'h2000_0022); push(2, 32'hE000_0022);
    cfg(1, 1, 2'b01); cfg(2, 1, 2'b00);
    exp = '{32'h2000_0022, 32'hE000_0022};
    run_token();
    cmp_stream("R3 hold skips link");
    all_off(); cfg(1, 1, 2'b00);
    exp = '{32'h1000_0011, 32'hE000_0011};
    run_token();
    cmp_stream("R3 held event later");
  endtask

  task automatic t_flush();
    all_off();
    push(4, 32'h4000_0001); push(4, 32'hE000_0041);
    push(4, 32'h4000_0002); push(4, 32'hE000_0042);
    cfg(4, 1, 2'b10);
    exp.delete();
    run_token();
    cmp_stream("R4 flush outputs nothing");
    cfg(4, 1, 2'b00);
    exp = '{32'hEF00_0004};
    run_token();
    cmp_stream("R4 buffer emptied");
    check(tmo_flag[4] == 1, "R7 tmo flag set", W'(tmo_flag), W'(1 << 4));
  endtask

  task automatic t_second();
    all_off();
    push(6, 32'h1000_0001); push(6, 32'hE000_0001);
    push(6, 32'h2000_0002); push(6, 32'h2000_0003); push(6, 32'hE000_0002);
    cfg(6, 1, 2'b11);
    exp = '{32'h2000_0002, 32'h2000_0003, 32'hE000_0002};
    run_token();
    cmp_stream("R5 second event");
  endtask

  task automatic t_static_off();
    all_off();
    push(7, 32'h7000_0007); push(7, 32'hE000_0007);
    link_mode[15:14] = 2'b00;
    exp.delete();
    run_token();
    cmp_stream("R6 off link skipped");
    cfg(7, 1, 2'b00);
    exp = '{32'h7000_0007, 32'hE000_0007};
    run_token();
    cmp_stream("R6 off data untouched");
  endtask

  task automatic t_timeout();
    int lat;
    all_off(); cfg(10, 1, 2'b00);
    tmo_cycles = 16'd40;
    exp = '{32'hEF00_000A};
    run_token();
    cmp_stream("R7 timeout word");
    lat = first_out_cyc - (cyc - 0);
    check(tmo_flag[10] == 1, "R7 tmo flag link10", W'(tmo_flag), W'(1 << 10));
    check(trl_cnt == 1, "R10 timeout counts as trailer", W'(trl_cnt), 1);
    tmo_cycles = 16'd20;
  endtask

  task automatic t_overflow();
    all_off();
    for (int i = 0; i < 258; i++) push(8, 32'h8000_0000 + i);
    check(ovf_flag == 12'h100, "R8 ovf flag", W'(ovf_flag), 32'h100);
    cfg(8, 1, 2'b10);
    exp.delete();
    run_token();
    cmp_stream("R8 flush after overflow");
    check(ovf_flag[8] == 1, "R8 ovf sticky", W'(ovf_flag), 32'h100);
  endtask

  task automatic t_limit();
    all_off();
    for (int i = 0; i < 3; i++) push(9, 32'hE000_0090 + i);
    repeat (2) @(negedge clk);
    check(ht_limit[9] == 0 && busy == 0, "R9 below limit", W'({ht_limit, busy}), 0);
    push(9, 32'hE000_0093);
    repeat (2) @(negedge clk);
    check(ht_limit == 12'h200 && busy == 1, "R9 limit and busy",
          W'({ht_limit, busy}), W'({12'h200, 1'b1}));
    cfg(9, 1, 2'b00);
    exp = '{32'hE000_0090};
    run_token();
    cmp_stream("R9 one event read");
    check(ht_limit == 0 && busy == 0, "R9 limit released", W'({ht_limit, busy}), 0);
    cfg(9, 1, 2'b10);
    run_token();
  endtask

  task automatic t_halt();
    int t0;
    all_off();
    push(11, 32'hB000_000B); push(11, 32'hE000_000B);
    cfg(11, 1, 2'b00);
    tmo_cycles = 16'd5;
    halt = 1;
    got.delete(); tok_cnt = 0;
    @(negedge clk); token_in = 1;
    @(negedge clk); token_in = 0;
    t0 = cyc;
    while (cyc - t0 < 60) @(negedge clk);
    check(got.size() == 0, "R11 no output under halt", W'(got.size()), 0);
    check(tmo_flag[11] == 0, "R11 no timeout under halt", W'(tmo_flag), 0);
    halt = 0;
    while (tok_cnt == 0 && cyc - t0 < 2000) @(negedge clk);
    repeat (2) @(negedge clk);
    exp = '{32'hB000_000B, 32'hE000_000B};
    cmp_stream("R11 resumes after halt");
    tmo_cycles = 16'd20;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_hold();
    t_flush();
    t_second();
    t_static_off();
    t_timeout();
    t_overflow();
    t_limit();
    t_halt();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule